// File: doc/BRIEF.md
# AAL3/4 Per-Cell Reassembly Checker

This block judges each received AAL3/4 segmentation cell of one virtual connection before its payload goes into reassembly. It takes the fields that an upstream parser has already pulled from the cell: the 2-bit segment type, the multiplexing identifier, the 6-bit length indicator and a flag that says whether the CRC-10 matched. It also takes the connection's check enables and its identifier window. For each cell it returns one decision, registered one cycle after the cell. The decision says whether the cell is accepted or discarded. It can also ask for a status-queue entry that flags an abort, a length error or a sequence error.

The block keeps the connection's expected-segment state. That state says whether the next cell should open a message or continue one. The block also keeps four saturating error counters, one each for CRC, identifier, length and sequence faults. The checks run in a fixed order: CRC, identifier, abort marker, length, sequence. A cell stops at the first check it fails. Every status entry raised here describes a truncated message, so its reported length is zero, and that length is not carried on a port.

Top module: `aal34_cell_checker`

## Requirements
- R1: During and right after reset, decValid, decAccept and stsWr are 0, expSeg is 01 and all four error counters are 0.
- R2: If crcChkEn is 1 and crcOk is 0, the cell is discarded and crcErrCnt goes up by one. No status entry is written and expSeg is unchanged.
- R3: A MID is valid when midBase <= cellMid < midBase + 2^midBits. An invalid MID makes the cell discarded, raises midErrCnt by one and leaves expSeg unchanged.
- R4: Segment types are encoded as COM=00, EOM=01, BOM=10 and SSM=11. An EOM with length indicator 63 is discarded and writes a status entry with only stsAbort set. expSeg becomes 01 and no counter changes. This applies whether liChkEn is set or not.
- R5: With liChkEn set, a BOM whose length indicator is not 44, or an SSM whose length indicator is outside 8..44, is discarded. liErrCnt goes up by one, no status entry is written and expSeg is unchanged.
- R6: With liChkEn set, a COM whose length indicator is not 44, or an EOM whose length indicator is outside 4..44, is discarded. It writes a status entry with only stsLenErr set, raises liErrCnt by one and sets expSeg to 01.
- R7: With seqChkEn set and expSeg=01, an arriving COM or EOM is discarded with no status entry and no counter change.
- R8: With seqChkEn set and expSeg=00, an arriving BOM or SSM writes a status entry with only stsSeqErr set and raises seqErrCnt by one. The cell is still accepted.
- R9: An accepted BOM or COM sets expSeg to 00. An accepted EOM or SSM sets expSeg to 01.
- R10: The checks run in the order CRC, MID, abort marker, length, sequence. Only the first failing check has any effect.
- R11: Each error counter holds at its all-ones value and does not wrap.
- R12: Clearing crcChkEn, liChkEn or seqChkEn turns off that check. The cell then goes on to the later checks.
- R13: Every cell presented with cellValid gives exactly one decValid pulse on the following clock cycle. With no cell, decValid, decAccept and stsWr stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellValid | input | 1 | A parsed cell is present this cycle |
| segType | input | 2 | Segment type: COM=00, EOM=01, BOM=10, SSM=11 |
| cellMid | input | MID_W | Multiplexing identifier of the cell |
| cellLi | input | 6 | Length indicator of the cell |
| crcOk | input | 1 | CRC-10 of the cell matched |
| crcChkEn | input | 1 | Enable the CRC check |
| liChkEn | input | 1 | Enable the length-indicator check |
| seqChkEn | input | 1 | Enable the segment-sequence check |
| midBase | input | MID_W | Lowest valid MID |
| midBits | input | MBITS_W | log2 of the number of valid MIDs |
| decValid | output | 1 | Decision for the previous cycle's cell |
| decAccept | output | 1 | Cell accepted (otherwise discarded) |
| stsWr | output | 1 | Status-queue write request |
| stsAbort | output | 1 | Status entry: message aborted |
| stsLenErr | output | 1 | Status entry: length error |
| stsSeqErr | output | 1 | Status entry: sequence error |
| expSeg | output | 2 | Expected-segment state (01 begin, 00 continue) |
| crcErrCnt | output | CNT_W | CRC error counter |
| midErrCnt | output | CNT_W | MID error counter |
| liErrCnt | output | CNT_W | Length error counter |
| seqErrCnt | output | CNT_W | Sequence error counter |

## Verification
The hardest cases to reach are those where the expected-segment state and a failing check have to line up. One is a COM with a bad length that arrives mid-message, so it ends the message with a length status. Another is a BOM or SSM that arrives while a continuation is expected. The stimulus first steers the state with accepted BOM cells and then sends the faulty cell. Priority is tested with cells that carry two faults at once, for example a bad CRC together with a bad MID. Counter saturation uses a narrow counter width and a long burst of CRC failures.

// File: rtl/aal34_chk_pkg.sv
package aal34_chk_pkg;

  typedef enum logic [1:0] {
    SEG_COM = 2'b00,
    SEG_EOM = 2'b01,
    SEG_BOM = 2'b10,
    SEG_SSM = 2'b11
  } segKind_t;

  localparam logic [1:0] EXP_BEGIN = 2'b01;
  localparam logic [1:0] EXP_CONT  = 2'b00;

  localparam int NUM_CNT  = 4;
  localparam int CNT_CRC  = 0;
  localparam int CNT_MID  = 1;
  localparam int CNT_LI   = 2;
  localparam int CNT_SEQ  = 3;

  localparam logic [5:0] LI_FULL    = 6'd44;
  localparam logic [5:0] LI_ABORT   = 6'd63;
  localparam logic [5:0] LI_EOM_MIN = 6'd4;
  localparam logic [5:0] LI_SSM_MIN = 6'd8;

  typedef struct packed {
    logic               fire;
    logic               accept;
    logic               stsWr;
    logic               stsAbort;
    logic               stsLenErr;
    logic               stsSeqErr;
    logic [NUM_CNT-1:0] cntInc;
    logic               expLoad;
    logic [1:0]         expNext;
  } stepStrobe_t;

endpackage

// File: rtl/aal34_sat_counter.sv
module aal34_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (inc && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/aal34_chk_ctrl.sv
module aal34_chk_ctrl
  import aal34_chk_pkg::*;
#(
  parameter int MID_W   = 10,
  parameter int MBITS_W = 4
) (
  input  logic               cellValid,
  input  logic [1:0]         segType,
  input  logic [MID_W-1:0]   cellMid,
  input  logic [5:0]         cellLi,
  input  logic               crcOk,
  input  logic               crcChkEn,
  input  logic               liChkEn,
  input  logic               seqChkEn,
  input  logic [MID_W-1:0]   midBase,
  input  logic [MBITS_W-1:0] midBits,
  input  logic [1:0]         expSeg,
  output stepStrobe_t        strobe
);

  segKind_t       seg;
  logic [MID_W:0] midOffset;
  logic [MID_W:0] midSpan;
  logic           midOk;
  logic           crcFail;
  logic           abortEom;
  logic           liBad;
  logic           liFail;
  logic           isOpen;
  logic           isClose;
  logic           expBegin;
  logic           seqDrop;
  logic           seqRestart;

  assign seg       = segKind_t'(segType);
  assign midOffset = {1'b0, cellMid} - {1'b0, midBase};
  assign midSpan   = midOffset >> midBits;
  assign midOk     = (midSpan == '0);

  assign crcFail   = crcChkEn && !crcOk;
  assign abortEom  = (seg == SEG_EOM) && (cellLi == LI_ABORT);
  assign isOpen    = (seg == SEG_BOM) || (seg == SEG_SSM);
  assign isClose   = (seg == SEG_EOM) || (seg == SEG_SSM);
  assign expBegin  = (expSeg == EXP_BEGIN);

  always_comb begin
    unique case (seg)
      SEG_BOM: liBad = (cellLi != LI_FULL);
      SEG_COM: liBad = (cellLi != LI_FULL);
      SEG_EOM: liBad = (cellLi < LI_EOM_MIN) || (cellLi > LI_FULL);
      SEG_SSM: liBad = (cellLi < LI_SSM_MIN) || (cellLi > LI_FULL);
      default: liBad = 1'b0;
    endcase
  end

  assign liFail     = liChkEn && liBad;
  assign seqDrop    = seqChkEn && expBegin && !isOpen;
  assign seqRestart = seqChkEn && !expBegin && isOpen;

  always_comb begin
    strobe      = '0;
    strobe.fire = cellValid;
    if (cellValid) begin
      if (crcFail) begin
        strobe.cntInc[CNT_CRC] = 1'b1;
      end else if (!midOk) begin
        strobe.cntInc[CNT_MID] = 1'b1;
      end else if (abortEom) begin
        strobe.stsWr    = 1'b1;
        strobe.stsAbort = 1'b1;
        strobe.expLoad  = 1'b1;
        strobe.expNext  = EXP_BEGIN;
      end else if (liFail) begin
        strobe.cntInc[CNT_LI] = 1'b1;
        if (!isOpen) begin
          strobe.stsWr     = 1'b1;
          strobe.stsLenErr = 1'b1;
          strobe.expLoad   = 1'b1;
          strobe.expNext   = EXP_BEGIN;
        end
      end else if (seqDrop) begin
        strobe.accept = 1'b0;
      end else begin
        strobe.accept  = 1'b1;
        strobe.expLoad = 1'b1;
        strobe.expNext = isClose ? EXP_BEGIN : EXP_CONT;
        if (seqRestart) begin
          strobe.stsWr           = 1'b1;
          strobe.stsSeqErr       = 1'b1;
          strobe.cntInc[CNT_SEQ] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/aal34_chk_datapath.sv
module aal34_chk_datapath
  import aal34_chk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  stepStrobe_t                  strobe,
  output logic                         decValid,
  output logic                         decAccept,
  output logic                         stsWr,
  output logic                         stsAbort,
  output logic                         stsLenErr,
  output logic                         stsSeqErr,
  output logic [1:0]                   expSeg,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVal
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
      stsWr     <= 1'b0;
      stsAbort  <= 1'b0;
      stsLenErr <= 1'b0;
      stsSeqErr <= 1'b0;
    end else begin
      decValid  <= strobe.fire;
      decAccept <= strobe.accept;
      stsWr     <= strobe.stsWr;
      stsAbort  <= strobe.stsAbort;
      stsLenErr <= strobe.stsLenErr;
      stsSeqErr <= strobe.stsSeqErr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expSeg <= EXP_BEGIN;
    end else if (strobe.expLoad) begin
      expSeg <= strobe.expNext;
    end
  end

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : gCnt
    aal34_sat_counter #(.CNT_W(CNT_W)) uCnt (
      .clk  (clk),
      .rstN (rstN),
      .inc  (strobe.cntInc[gi]),
      .cnt  (cntVal[gi])
    );
  end

endmodule

// File: rtl/aal34_cell_checker.sv
module aal34_cell_checker
  import aal34_chk_pkg::*;
#(
  parameter int MID_W   = 10,
  parameter int CNT_W   = 8,
  localparam int MBITS_W = $clog2(MID_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cellValid,
  input  logic [1:0]         segType,
  input  logic [MID_W-1:0]   cellMid,
  input  logic [5:0]         cellLi,
  input  logic               crcOk,
  input  logic               crcChkEn,
  input  logic               liChkEn,
  input  logic               seqChkEn,
  input  logic [MID_W-1:0]   midBase,
  input  logic [MBITS_W-1:0] midBits,
  output logic               decValid,
  output logic               decAccept,
  output logic               stsWr,
  output logic               stsAbort,
  output logic               stsLenErr,
  output logic               stsSeqErr,
  output logic [1:0]         expSeg,
  output logic [CNT_W-1:0]   crcErrCnt,
  output logic [CNT_W-1:0]   midErrCnt,
  output logic [CNT_W-1:0]   liErrCnt,
  output logic [CNT_W-1:0]   seqErrCnt
);

  stepStrobe_t                   strobe;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;

  aal34_chk_ctrl #(.MID_W(MID_W), .MBITS_W(MBITS_W)) uCtrl (
    .cellValid (cellValid),
    .segType   (segType),
    .cellMid   (cellMid),
    .cellLi    (cellLi),
    .crcOk     (crcOk),
    .crcChkEn  (crcChkEn),
    .liChkEn   (liChkEn),
    .seqChkEn  (seqChkEn),
    .midBase   (midBase),
    .midBits   (midBits),
    .expSeg    (expSeg),
    .strobe    (strobe)
  );

  aal34_chk_datapath #(.CNT_W(CNT_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .decValid  (decValid),
    .decAccept (decAccept),
    .stsWr     (stsWr),
    .stsAbort  (stsAbort),
    .stsLenErr (stsLenErr),
    .stsSeqErr (stsSeqErr),
    .expSeg    (expSeg),
    .cntVal    (cntVal)
  );

  assign crcErrCnt = cntVal[CNT_CRC];
  assign midErrCnt = cntVal[CNT_MID];
  assign liErrCnt  = cntVal[CNT_LI];
  assign seqErrCnt = cntVal[CNT_SEQ];

endmodule

// File: rtl/aal34_cell_checker_chk.sv
module aal34_cell_checker_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cellValid,
  input logic             crcOk,
  input logic             crcChkEn,
  input logic             decValid,
  input logic             decAccept,
  input logic             stsWr,
  input logic             stsAbort,
  input logic             stsLenErr,
  input logic             stsSeqErr,
  input logic [1:0]       expSeg,
  input logic [CNT_W-1:0] crcErrCnt,
  input logic [CNT_W-1:0] liErrCnt
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  AST_CRC_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (cellValid && crcChkEn && !crcOk) |=> (decValid && !decAccept && !stsWr)); // R2

  AST_STS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stsWr |-> ($countones({stsAbort, stsLenErr, stsSeqErr}) == 1)); // R4

  AST_LEN_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    stsLenErr |-> (!decAccept && expSeg == 2'b01)); // R6

  AST_SEQ_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    stsSeqErr |-> decAccept); // R8

  AST_EXP_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (expSeg == 2'b00) || (expSeg == 2'b01)); // R9

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (crcErrCnt == CNT_TOP) |=> (crcErrCnt == CNT_TOP)); // R11

  AST_LI_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (liErrCnt == CNT_TOP) |=> (liErrCnt == CNT_TOP)); // R11

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    cellValid |=> decValid); // R13

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> (!stsWr && !decAccept)); // R13

endmodule

bind aal34_cell_checker aal34_cell_checker_chk #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cellValid (cellValid),
  .crcOk     (crcOk),
  .crcChkEn  (crcChkEn),
  .decValid  (decValid),
  .decAccept (decAccept),
  .stsWr     (stsWr),
  .stsAbort  (stsAbort),
  .stsLenErr (stsLenErr),
  .stsSeqErr (stsSeqErr),
  .expSeg    (expSeg),
  .crcErrCnt (crcErrCnt),
  .liErrCnt  (liErrCnt)
);

// File: tb/sim_aal34_cell_checker.sv
`timescale 1ns/1ps
module sim_aal34_cell_checker;

  localparam int MID_W   = 10;
  localparam int CNT_W   = 4;
  localparam int MBITS_W = $clog2(MID_W + 1);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  localparam logic [1:0] COM = 2'b00, EOM = 2'b01, BOM = 2'b10, SSM = 2'b11;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               cellValid = 1'b0;
  logic [1:0]         segType = 2'b00;
  logic [MID_W-1:0]   cellMid = '0;
  logic [5:0]         cellLi = '0;
  logic               crcOk = 1'b1;
  logic               crcChkEn = 1'b1;
  logic               liChkEn = 1'b1;
  logic               seqChkEn = 1'b1;
  logic [MID_W-1:0]   midBase = 10'd16;
  logic [MBITS_W-1:0] midBits = 4'd2;
  logic               decValid, decAccept, stsWr, stsAbort, stsLenErr, stsSeqErr;
  logic [1:0]         expSeg;
  logic [CNT_W-1:0]   crcErrCnt, midErrCnt, liErrCnt, seqErrCnt;

  always #5 clk = ~clk;

  aal34_cell_checker #(.MID_W(MID_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .cellValid(cellValid), .segType(segType),
    .cellMid(cellMid), .cellLi(cellLi), .crcOk(crcOk), .crcChkEn(crcChkEn),
    .liChkEn(liChkEn), .seqChkEn(seqChkEn), .midBase(midBase), .midBits(midBits),
    .decValid(decValid), .decAccept(decAccept), .stsWr(stsWr), .stsAbort(stsAbort),
    .stsLenErr(stsLenErr), .stsSeqErr(stsSeqErr), .expSeg(expSeg),
    .crcErrCnt(crcErrCnt), .midErrCnt(midErrCnt), .liErrCnt(liErrCnt),
    .seqErrCnt(seqErrCnt)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected vector: accept, stsWr, abort, lenErr, seqErr, expSeg, 4 counters
  localparam int VEC_W = 7 + 4 * CNT_W;
  logic [VEC_W-1:0] expQ[$];
  string            reqQ[$];

  // reference state
  logic [1:0] mExp = 2'b01;
  int         mCnt[4] = '{0, 0, 0, 0};

  function automatic int bump(int v);
    return (v >= CNT_MAX) ? CNT_MAX : v + 1;
  endfunction

  task automatic sendCell(input logic [1:0] st, input int mid, input int li,
                          input bit good, input string req);
    bit acc = 0, sw = 0, ab = 0, le = 0, se = 0;
    bit midOk, liBad, open;
    midOk = (mid >= int'(midBase)) && (mid < int'(midBase) + (1 << midBits));
    open  = (st == BOM) || (st == SSM);
    case (st)
      BOM, COM: liBad = (li != 44);
      EOM:      liBad = (li < 4) || (li > 44);
      default:  liBad = (li < 8) || (li > 44);
    endcase
    if (crcChkEn && !good) mCnt[0] = bump(mCnt[0]);
    else if (!midOk) mCnt[1] = bump(mCnt[1]);
    else if (st == EOM && li == 63) begin sw = 1; ab = 1; mExp = 2'b01; end
    else if (liChkEn && liBad) begin
      mCnt[2] = bump(mCnt[2]);
      if (!open) begin sw = 1; le = 1; mExp = 2'b01; end
    end else if (seqChkEn && mExp == 2'b01 && !open) begin
      acc = 0;
    end else begin
      acc = 1;
      if (seqChkEn && mExp == 2'b00 && open) begin sw = 1; se = 1; mCnt[3] = bump(mCnt[3]); end
      mExp = (st == EOM || st == SSM) ? 2'b01 : 2'b00;
    end
    @(negedge clk);
    cellValid = 1'b1;
    segType   = st;
    cellMid   = MID_W'(mid);
    cellLi    = 6'(li);
    crcOk     = good;
    expQ.push_back({acc, sw, ab, le, se, mExp, CNT_W'(mCnt[0]), CNT_W'(mCnt[1]),
                    CNT_W'(mCnt[2]), CNT_W'(mCnt[3])});
    reqQ.push_back(req);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cellValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (decValid) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R13: decision with no cell pending, actual decValid=1 expected 0");
        end else begin
          logic [VEC_W-1:0] e, a;
          string r;
          e = expQ.pop_front();
          r = reqQ.pop_front();
          a = {decAccept, stsWr, stsAbort, stsLenErr, stsSeqErr, expSeg,
               crcErrCnt, midErrCnt, liErrCnt, seqErrCnt};
          if (a !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", r, a, e);
          end
        end
      end else if (stsWr || decAccept) begin
        checks++;
        errors++;
        $display("FAIL R13: idle outputs active, actual stsWr=%b decAccept=%b expected 0 0",
                 stsWr, decAccept);
      end
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung run, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (decValid || decAccept || stsWr || expSeg !== 2'b01 ||
        crcErrCnt != 0 || midErrCnt != 0 || liErrCnt != 0 || seqErrCnt != 0) begin
      errors++;
      $display("FAIL R1: reset state actual v=%b a=%b w=%b exp=%b cnt=%h%h%h%h expected 0 0 0 01 0000",
               decValid, decAccept, stsWr, expSeg, crcErrCnt, midErrCnt, liErrCnt, seqErrCnt);
    end
    rstN = 1'b1;
    // R9: normal flows, R13 one-cycle latency
    sendCell(SSM, 16, 20, 1, "R9");
    sendCell(BOM, 17, 44, 1, "R9");
    sendCell(COM, 18, 44, 1, "R13");
    sendCell(EOM, 19, 10, 1, "R9");
    // R2 CRC fail
    sendCell(BOM, 16, 44, 0, "R2");
    // R3 MID window 16..19
    sendCell(BOM, 20, 44, 1, "R3");
    sendCell(BOM, 15, 44, 1, "R3");
    sendCell(BOM, 19, 44, 1, "R3");
    sendCell(EOM, 16, 4, 1, "R6");
    // R10 priority
    sendCell(BOM, 40, 44, 0, "R10");
    sendCell(BOM, 40, 3, 1, "R10");
    sendCell(COM, 16, 3, 1, "R10");
    // R5 length faults without status
    sendCell(BOM, 16, 40, 1, "R5");
    sendCell(SSM, 16, 7, 1, "R5");
    sendCell(SSM, 16, 45, 1, "R5");
    sendCell(SSM, 16, 8, 1, "R5");
    sendCell(SSM, 16, 44, 1, "R5");
    // R6 length faults that end the message
    sendCell(BOM, 16, 44, 1, "R6");
    sendCell(COM, 16, 43, 1, "R6");
    sendCell(BOM, 16, 44, 1, "R6");
    sendCell(EOM, 16, 3, 1, "R6");
    sendCell(BOM, 16, 44, 1, "R6");
    sendCell(EOM, 16, 45, 1, "R6");
    // R4 abort marker
    sendCell(BOM, 16, 44, 1, "R4");
    sendCell(EOM, 16, 63, 1, "R4");
    // R7 continuation while a beginning is expected
    sendCell(COM, 16, 44, 1, "R7");
    sendCell(EOM, 16, 10, 1, "R7");
    // R8 restart cases
    sendCell(BOM, 16, 44, 1, "R8");
    sendCell(BOM, 17, 44, 1, "R8");
    sendCell(SSM, 17, 20, 1, "R8");
    idle(2);
    // R12 enables off
    liChkEn = 1'b0;
    sendCell(BOM, 16, 3, 1, "R12");
    sendCell(EOM, 16, 63, 1, "R4");
    idle(1);
    seqChkEn = 1'b0;
    sendCell(COM, 16, 44, 1, "R12");
    sendCell(BOM, 16, 44, 1, "R12");
    idle(1);
    crcChkEn = 1'b0;
    sendCell(SSM, 16, 3, 0, "R12");
    idle(1);
    crcChkEn = 1'b1; liChkEn = 1'b1; seqChkEn = 1'b1;
    // R11 saturation
    for (int i = 0; i < 20; i++) sendCell(BOM, 16, 44, 0, "R11");
    for (int i = 0; i < 18; i++) sendCell(SSM, 16, 2, 1, "R11");
    idle(3);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R13: decisions missing, actual %0d pending expected 0", expQ.size());
    end
    finishRun();
  end

endmodule